// File: doc/BRIEF.md
# Performance Monitor Interrupt Controller

This block sits beside a bank of event counters and decides when those counters should stop, when they should start, and when the monitor should ask the core for an interrupt. It watches two event sources. The first is a free-running 64-bit time base, where a 0-to-1 change on one of four selectable bit positions counts as an event. The second is an external system-management interrupt line, which software may redirect so that it becomes a monitor interrupt. Each event is gated through a small control register before it can drive any action.

A signaled interrupt is held as a sticky pending flag until the core acknowledges it. The pending request competes with the external and decrementer interrupt requests in a fixed-priority selector, and the selector issues a grant only while interrupts are globally enabled. When the controller signals an interrupt, it captures the address of the most recently completed instruction. It skips that capture while counting is frozen.

Top module: `perf_irq_ctrl`

## Requirements
- R1: The control register loads `cfg_wdata` on a cycle with `cfg_we` high and takes effect from the next cycle. Its bit layout is: bit 0 freeze-all, bit 1 time-base event enable, bits 3:2 tap select, bit 4 freeze-on-event, bit 5 trigger-on-event, bit 6 exception enable, bit 7 SMI redirect.
- R2: A time-base event occurs only when the time-base event enable is 1 and the selected tap goes from 0 to 1 between consecutive cycles. Tap select values 0, 1, 2 and 3 choose `tb_value` bits 63, 55, 51 and 47. A level that stays high raises no further event.
- R3: A time-base event raises a one-cycle `freeze_pulse` on the cycle after the event when freeze-on-event is set, and a one-cycle `trigger_pulse` when trigger-on-event is set. Neither pulse is raised while freeze-all is set.
- R4: Rewriting the tap select while the time-base event is enabled compares the previously selected bit with the newly selected one. A new tap reading 1 where the old one read 0 acts as an event on the first cycle the new select is in effect.
- R5: With SMI redirect set, a high `smi_in` counts as a monitor event and `smi_exc_req` stays low. With SMI redirect clear, `smi_exc_req` follows `smi_in` one cycle later and `smi_in` causes no monitor event.
- R6: `pm_pending` sets on the cycle after a time-base or SMI event only when exception enable is set. It also sets while freeze-all is set. It stays set until `irq_ack`, and a new event in the same cycle as the acknowledge wins.
- R7: Each event that sets the pending flag loads `sampled_addr` with the address of the last completion reported before the event cycle. While freeze-all is set, `sampled_addr` does not change.
- R8: `grant` is combinational and one-hot or zero: bit 2 external, bit 1 monitor, bit 0 decrementer. The external request ranks above the monitor request, which ranks above the decrementer request. All grant bits are zero while `glb_irq_en` is 0.
- R9: After reset, all pulses, `pm_pending`, `smi_exc_req`, `sampled_addr` and `grant` read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| tb_value | input | TB_W | Free-running time base |
| smi_in | input | 1 | External system-management interrupt |
| cmpl_valid | input | 1 | An instruction completed this cycle |
| cmpl_addr | input | AW | Effective address of the completed instruction |
| glb_irq_en | input | 1 | Global interrupt enable |
| ext_req | input | 1 | External interrupt request |
| dec_req | input | 1 | Decrementer interrupt request |
| irq_ack | input | 1 | Monitor interrupt taken, clears pending |
| freeze_pulse | output | 1 | Freeze the event counters |
| trigger_pulse | output | 1 | Start the event counters |
| smi_exc_req | output | 1 | Non-redirected SMI exception request |
| pm_pending | output | 1 | Sticky monitor interrupt request |
| sampled_addr | output | AW | Captured completion address |
| grant | output | 3 | One-hot interrupt grant {ext, monitor, dec} |

## Verification
The edge detector is driven with a rising bit on the selected tap, a bit that stays high, a rise on a tap that is not selected, and a falling bit. Together these separate true edge detection from level sensing and from the wrong tap. A select rewrite onto a tap that already reads 1 shows whether the detector compares old and new selections or resynchronises silently. The SMI input is applied once with redirect and once without, to separate the two routes. The selector is tried with the monitor request alone, against the external request, against the decrementer request, and with global enable low, which fixes the full ordering. A freeze-all run with exceptions enabled separates the pending path from the suppressed pulse and capture paths.

// File: rtl/perf_irq_pkg.sv
package perf_irq_pkg;

  localparam int unsigned SEL_W = 2;
  localparam int unsigned NTAP  = 1 << SEL_W;
  localparam int unsigned CFG_W = 8;

  // Time-base bit positions picked by the select field, index = select value
  localparam int unsigned TB_TAPS [NTAP] = '{63, 55, 51, 47};

  // Request indices into the priority selector; higher index wins
  localparam int unsigned REQ_DEC = 0;
  localparam int unsigned REQ_PM  = 1;
  localparam int unsigned REQ_EXT = 2;
  localparam int unsigned NREQ    = 3;

  // Control register, MSB first: bit7 .. bit0
  typedef struct packed {
    logic             smi_redir;
    logic             exc_en;
    logic             trig_en;
    logic             frz_cond;
    logic [SEL_W-1:0] tb_sel;
    logic             tb_en;
    logic             frz_all;
  } pm_cfg_t;

endpackage

// File: rtl/pmi_tb_edge.sv
module pmi_tb_edge
  import perf_irq_pkg::*;
#(
  parameter int unsigned TB_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TB_W-1:0]  tb_value,
  input  logic [SEL_W-1:0] tb_sel,
  input  logic             tb_en,
  output logic             tb_event
);

  logic [NTAP-1:0] tap_bits;
  logic            sel_bit;
  logic            prev_q;
  logic            prev_d;

  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    assign tap_bits[g] = tb_value[TB_TAPS[g]];
  end

  // The value under the current select is compared with the value that
  // the select in force last cycle returned, so a select change can edge.
  always_comb begin
    sel_bit  = tap_bits[tb_sel];
    prev_d   = sel_bit;
    tb_event = tb_en & sel_bit & ~prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

endmodule

// File: rtl/pmi_req_gate.sv
module pmi_req_gate
  import perf_irq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  pm_cfg_t cfg,
  input  logic    tb_event,
  input  logic    smi_in,
  input  logic    irq_ack,
  output logic    freeze_pulse,
  output logic    trigger_pulse,
  output logic    smi_exc_req,
  output logic    pm_pending,
  output logic    capture
);

  logic smi_event;
  logic any_event;
  logic frz_d, trg_d, smi_d, pend_d;
  logic frz_q, trg_q, smi_q, pend_q;

  always_comb begin
    smi_event = cfg.smi_redir & smi_in;
    any_event = (tb_event | smi_event) & cfg.exc_en;
    frz_d     = tb_event & cfg.frz_cond & ~cfg.frz_all;
    trg_d     = tb_event & cfg.trig_en  & ~cfg.frz_all;
    smi_d     = smi_in & ~cfg.smi_redir;
    pend_d    = pend_q;
    if (irq_ack)   pend_d = 1'b0;
    if (any_event) pend_d = 1'b1;
    capture   = any_event & ~cfg.frz_all;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frz_q  <= 1'b0;
      trg_q  <= 1'b0;
      smi_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      frz_q  <= frz_d;
      trg_q  <= trg_d;
      smi_q  <= smi_d;
      pend_q <= pend_d;
    end
  end

  assign freeze_pulse  = frz_q;
  assign trigger_pulse = trg_q;
  assign smi_exc_req   = smi_q;
  assign pm_pending    = pend_q;

endmodule

// File: rtl/pmi_addr_sample.sv
module pmi_addr_sample #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmpl_valid,
  input  logic [AW-1:0] cmpl_addr,
  input  logic          capture,
  output logic [AW-1:0] sampled_addr
);

  logic [AW-1:0] last_q, last_d;
  logic [AW-1:0] samp_q, samp_d;

  always_comb begin
    last_d = last_q;
    if (cmpl_valid) last_d = cmpl_addr;
    samp_d = samp_q;
    if (capture) samp_d = last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      samp_q <= '0;
    end else begin
      if (cmpl_valid) last_q <= last_d;
      if (capture)    samp_q <= samp_d;
    end
  end

  assign sampled_addr = samp_q;

endmodule

// File: rtl/pmi_prio_arb.sv
module pmi_prio_arb #(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0] req,
  input  logic         enable,
  output logic [N-1:0] grant
);

  logic [N:0] taken;

  // Highest index has highest priority
  assign taken[N] = 1'b0;
  for (genvar i = N - 1; i >= 0; i--) begin : g_slot
    assign grant[i] = enable & req[i] & ~taken[i+1];
    assign taken[i] = taken[i+1] | req[i];
  end

endmodule

// File: rtl/perf_irq_ctrl.sv
module perf_irq_ctrl
  import perf_irq_pkg::*;
#(
  parameter int unsigned TB_W = 64,
  parameter int unsigned AW   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic [TB_W-1:0]  tb_value,
  input  logic             smi_in,
  input  logic             cmpl_valid,
  input  logic [AW-1:0]    cmpl_addr,
  input  logic             glb_irq_en,
  input  logic             ext_req,
  input  logic             dec_req,
  input  logic             irq_ack,
  output logic             freeze_pulse,
  output logic             trigger_pulse,
  output logic             smi_exc_req,
  output logic             pm_pending,
  output logic [AW-1:0]    sampled_addr,
  output logic [NREQ-1:0]  grant
);

  pm_cfg_t         cfg_q, cfg_d;
  logic            tb_event;
  logic            capture;
  logic [NREQ-1:0] req_vec;

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_we) cfg_d = pm_cfg_t'(cfg_wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_d;
  end

  pmi_tb_edge #(.TB_W(TB_W)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .tb_value (tb_value),
    .tb_sel   (cfg_q.tb_sel),
    .tb_en    (cfg_q.tb_en),
    .tb_event (tb_event)
  );

  pmi_req_gate u_gate (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg           (cfg_q),
    .tb_event      (tb_event),
    .smi_in        (smi_in),
    .irq_ack       (irq_ack),
    .freeze_pulse  (freeze_pulse),
    .trigger_pulse (trigger_pulse),
    .smi_exc_req   (smi_exc_req),
    .pm_pending    (pm_pending),
    .capture       (capture)
  );

  pmi_addr_sample #(.AW(AW)) u_addr (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmpl_valid   (cmpl_valid),
    .cmpl_addr    (cmpl_addr),
    .capture      (capture),
    .sampled_addr (sampled_addr)
  );

  always_comb begin
    req_vec          = '0;
    req_vec[REQ_EXT] = ext_req;
    req_vec[REQ_PM]  = pm_pending;
    req_vec[REQ_DEC] = dec_req;
  end

  pmi_prio_arb #(.N(NREQ)) u_arb (
    .req    (req_vec),
    .enable (glb_irq_en),
    .grant  (grant)
  );

endmodule

// File: rtl/perf_irq_ctrl_chk.sv
module perf_irq_ctrl_chk
  import perf_irq_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input pm_cfg_t         cfg_q,
  input logic            smi_in,
  input logic            glb_irq_en,
  input logic            ext_req,
  input logic            irq_ack,
  input logic            freeze_pulse,
  input logic            trigger_pulse,
  input logic            smi_exc_req,
  input logic            pm_pending,
  input logic [AW-1:0]   sampled_addr,
  input logic [NREQ-1:0] grant
);

  assert_freeze_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_pulse |-> $past(cfg_q.frz_cond && cfg_q.tb_en && !cfg_q.frz_all));

  assert_trigger_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trigger_pulse |-> $past(cfg_q.trig_en && cfg_q.tb_en && !cfg_q.frz_all));

  assert_smi_route_R5: assert property (@(posedge clk) disable iff (!rst_n)
    smi_exc_req |-> $past(smi_in && !cfg_q.smi_redir));

  assert_pend_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pm_pending) |-> $past(cfg_q.exc_en));

  assert_pend_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pm_pending) |-> $past(irq_ack));

  assert_addr_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_q.frz_all) |-> $stable(sampled_addr));

  assert_grant_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_grant_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |-> glb_irq_en);

  assert_ext_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_irq_en && ext_req) |-> (grant == 3'b100));

endmodule

bind perf_irq_ctrl perf_irq_ctrl_chk #(.AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_q         (cfg_q),
  .smi_in        (smi_in),
  .glb_irq_en    (glb_irq_en),
  .ext_req       (ext_req),
  .irq_ack       (irq_ack),
  .freeze_pulse  (freeze_pulse),
  .trigger_pulse (trigger_pulse),
  .smi_exc_req   (smi_exc_req),
  .pm_pending    (pm_pending),
  .sampled_addr  (sampled_addr),
  .grant         (grant)
);

// File: tb/perf_irq_ctrl_tb.sv
module perf_irq_ctrl_tb;

  localparam int TB_W = 64;
  localparam int AW   = 32;

  localparam int S_FRZ  = 0;
  localparam int S_TRG  = 1;
  localparam int S_PEND = 2;
  localparam int S_ADDR = 3;
  localparam int S_SMI  = 4;
  localparam int S_GNT  = 5;

  // Control bits as laid out in R1
  localparam logic [7:0] C_FALL = 8'h01;
  localparam logic [7:0] C_TBEN = 8'h02;
  localparam logic [7:0] C_FRZ  = 8'h10;
  localparam logic [7:0] C_TRG  = 8'h20;
  localparam logic [7:0] C_EXC  = 8'h40;
  localparam logic [7:0] C_SMIR = 8'h80;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            cfg_we;
  logic [7:0]      cfg_wdata;
  logic [TB_W-1:0] tb_value;
  logic            smi_in, cmpl_valid, glb_irq_en, ext_req, dec_req, irq_ack;
  logic [AW-1:0]   cmpl_addr;
  logic            freeze_pulse, trigger_pulse, smi_exc_req, pm_pending;
  logic [AW-1:0]   sampled_addr;
  logic [2:0]      grant;

  typedef struct {
    int          cyc;
    int          sig;
    logic [63:0] val;
    string       req;
  } item_t;

  item_t sb_q[$];
  int    cyc_cnt = 0;
  int    n_vec   = 0;
  int    n_bad   = 0;

  always #10 clk = ~clk;

  perf_irq_ctrl #(.TB_W(TB_W), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .tb_value(tb_value), .smi_in(smi_in), .cmpl_valid(cmpl_valid),
    .cmpl_addr(cmpl_addr), .glb_irq_en(glb_irq_en), .ext_req(ext_req),
    .dec_req(dec_req), .irq_ack(irq_ack), .freeze_pulse(freeze_pulse),
    .trigger_pulse(trigger_pulse), .smi_exc_req(smi_exc_req),
    .pm_pending(pm_pending), .sampled_addr(sampled_addr), .grant(grant)
  );

  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

  function automatic logic [63:0] observe(int s);
    case (s)
      S_FRZ:   return 64'(freeze_pulse);
      S_TRG:   return 64'(trigger_pulse);
      S_PEND:  return 64'(pm_pending);
      S_ADDR:  return 64'(sampled_addr);
      S_SMI:   return 64'(smi_exc_req);
      default: return 64'(grant);
    endcase
  endfunction

  // Monitor: pops the items due this cycle and compares them
  always @(negedge clk) begin
    #1;
    for (int i = sb_q.size() - 1; i >= 0; i--) begin
      if (sb_q[i].cyc == cyc_cnt) begin
        n_vec++;
        if (observe(sb_q[i].sig) !== sb_q[i].val) begin
          n_bad++;
          $display("FAIL %s sig%0d actual=%0h expected=%0h", sb_q[i].req,
                   sb_q[i].sig, observe(sb_q[i].sig), sb_q[i].val);
        end
        sb_q.delete(i);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic expect_at(int d, int s, logic [63:0] v, string r);
    item_t it;
    it.cyc = cyc_cnt + d;
    it.sig = s;
    it.val = v;
    it.req = r;
    sb_q.push_back(it);
  endtask

  task automatic wcfg(logic [7:0] v);
    tick();
    cfg_we    = 1'b1;
    cfg_wdata = v;
    tick();
    cfg_we    = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; tb_value = '0;
    smi_in = 1'b0; cmpl_valid = 1'b0; cmpl_addr = '0; glb_irq_en = 1'b0;
    ext_req = 1'b0; dec_req = 1'b0; irq_ack = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R9: reset state
    expect_at(0, S_FRZ, 0, "R9"); expect_at(0, S_TRG, 0, "R9");
    expect_at(0, S_PEND, 0, "R9"); expect_at(0, S_ADDR, 0, "R9");
    expect_at(0, S_SMI, 0, "R9"); expect_at(0, S_GNT, 0, "R9");

    tick(); cmpl_valid = 1'b1; cmpl_addr = 32'h1000;
    tick(); cmpl_valid = 1'b0;

    // R1 R2 R3 R7: freeze on tap 55 with exceptions enabled
    wcfg(C_TBEN | C_FRZ | C_EXC | 8'h04);
    tick();
    tick(); tb_value[55] = 1'b1; cmpl_valid = 1'b1; cmpl_addr = 32'h2000;
    expect_at(1, S_FRZ, 1, "R3"); expect_at(1, S_TRG, 0, "R3");
    expect_at(1, S_PEND, 1, "R6"); expect_at(1, S_ADDR, 32'h1000, "R7");
    expect_at(2, S_FRZ, 0, "R2");
    tick(); cmpl_valid = 1'b0;
    expect_at(0, S_GNT, 3'b000, "R8");
    // R8: priority ordering and global enable
    tick(); glb_irq_en = 1'b1; expect_at(0, S_GNT, 3'b010, "R8");
    tick(); ext_req = 1'b1; expect_at(0, S_GNT, 3'b100, "R8");
    expect_at(0, S_PEND, 1, "R6");
    tick(); ext_req = 1'b0; dec_req = 1'b1; expect_at(0, S_GNT, 3'b010, "R8");
    tick(); irq_ack = 1'b1;
    expect_at(1, S_PEND, 0, "R6"); expect_at(1, S_GNT, 3'b001, "R8");
    tick(); irq_ack = 1'b0;
    tick(); dec_req = 1'b0; glb_irq_en = 1'b0;

    // R3 R6: trigger without exception enable
    tb_value = '0;
    wcfg(C_TBEN | C_TRG | 8'h04);
    tick(); tb_value[55] = 1'b1;
    expect_at(1, S_TRG, 1, "R3"); expect_at(1, S_FRZ, 0, "R3");
    expect_at(1, S_PEND, 0, "R6");

    // R2: event enable clear
    tick(); tb_value = '0;
    wcfg(C_TRG | 8'h04);
    tick(); tb_value[55] = 1'b1; expect_at(1, S_TRG, 0, "R2");

    // R2: tap 51, rise on unselected tap ignored
    tick(); tb_value = '0;
    wcfg(C_TBEN | C_TRG | 8'h08);
    tick(); tb_value[55] = 1'b1; expect_at(1, S_TRG, 0, "R2");
    tick(); tb_value[51] = 1'b1; expect_at(1, S_TRG, 1, "R2");
    // falling tap raises nothing
    tick(); tb_value = '0; tb_value[47] = 1'b1; expect_at(1, S_TRG, 0, "R2");

    // R4: select moved onto tap 47 that already reads 1
    tick();
    wcfg(C_TBEN | C_TRG | 8'h0C);
    expect_at(1, S_TRG, 1, "R4");
    tick();

    // R5: redirected SMI
    tb_value = '0;
    wcfg(C_SMIR | C_EXC);
    tick(); smi_in = 1'b1;
    expect_at(1, S_PEND, 1, "R5"); expect_at(1, S_SMI, 0, "R5");
    expect_at(1, S_ADDR, 32'h2000, "R7");
    tick(); smi_in = 1'b0; irq_ack = 1'b1; expect_at(1, S_PEND, 0, "R6");
    tick(); irq_ack = 1'b0;
    // R5: plain SMI
    wcfg(C_EXC);
    tick(); smi_in = 1'b1;
    expect_at(1, S_SMI, 1, "R5"); expect_at(1, S_PEND, 0, "R5");
    tick(); smi_in = 1'b0; expect_at(1, S_SMI, 0, "R5");

    // R3 R6 R7: freeze-all suppresses pulses and capture, not pending
    wcfg(C_FALL | C_TBEN | C_FRZ | C_TRG | C_EXC | 8'h04);
    tick(); cmpl_valid = 1'b1; cmpl_addr = 32'h3000;
    tick(); cmpl_valid = 1'b0; tb_value[55] = 1'b1;
    expect_at(1, S_FRZ, 0, "R3"); expect_at(1, S_TRG, 0, "R3");
    expect_at(1, S_PEND, 1, "R6"); expect_at(1, S_ADDR, 32'h2000, "R7");

    repeat (4) tick();
    if (sb_q.size() != 0) begin
      n_bad++;
      $display("FAIL R9 pending items actual=%0d expected=0", sb_q.size());
    end
    finish_run();
  end

endmodule